// File: doc/BRIEF.md
# TDM Audio Frame Sync Generator

This block produces, or follows, the frame timing of a serial audio port. It runs on the bit clock and keeps two counters: the bit position inside a slot and the slot index inside a frame. The slot width is set in bit clocks. The slot count is 2 for stereo framing, 3 to 32 for general TDM, or 384 for a long special frame. A slot count of zero selects burst operation, where one single-slot frame is issued for each transfer request.

In internal mode the block drives the frame sync pin. The active pulse lasts either one bit clock or one whole slot, and its polarity is selectable. In external mode the pin is an input. The block watches for the active edge, realigns its counters to it, and flags an edge that comes at any point other than the frame boundary. The polarity setting applies in both modes. For each slot the block gives a strobe on the first data bit, placed 0, 1 or 2 bit clocks after the slot boundary. One instance serves transmit and another serves receive. The receive instance can take its sync from either the transmit pin or the receive pin.

Configuration is captured on every cycle while `enable` is low and held fixed while it is high.

Top module: `frame_sync_gen`

## Requirements
- R1: While disabled, and after reset, `syncOe`, `frameStart`, `slotFirstBit` and `syncErr` are 0, `slotIdx` is 0, and `syncOut` sits at its inactive level.
- R2: Configuration inputs are captured only while `enable` is low. A change made while enabled has no effect until the block is disabled and enabled again.
- R3: In internal periodic mode, `frameStart` is high in the first cycle after the clock edge that samples `enable` high. It then repeats every `cfgSlots*cfgSlotBits` cycles. `slotIdx` counts 0 to `cfgSlots-1` and steps once every `cfgSlotBits` cycles. `syncOe` is 1.
- R4: `cfgSlots` = 384 gives a frame of 384 slots, with a period of 384*`cfgSlotBits` cycles.
- R5: With `cfgInvert`=0 the inactive sync level is 0 and the active level is 1, so a rising edge marks frame start. With `cfgInvert`=1 both levels are swapped and a falling edge marks frame start. This applies both to the driven `syncOut` and to the external pin input.
- R6: With `cfgWordSync`=0, the sync is active only in the first bit clock of the frame. With `cfgWordSync`=1, it is active for the whole of slot 0.
- R7: `slotFirstBit` is high in the cycle whose bit position within the slot equals `cfgDelay`. The supported values of `cfgDelay` are 0, 1 and 2.
- R8: With `cfgSlots`=0 (burst), the block waits with the sync inactive. When `burstReq` is sampled high while waiting, one single-slot frame starts in the next cycle. Requests that arrive during that frame are ignored.
- R9: With `cfgExtSync`=1, `syncOe` is 0. An active edge on the selected pin, first sampled at clock edge t, gives `frameStart` with `slotIdx`=0 in the cycle after edge t+1. Before the first edge, no frame starts.
- R10: In external mode, an active edge that realigns the frame at its expected boundary raises no error. Any other edge raises a one-cycle `syncErr` pulse, and that pulse is coincident with the realigned `frameStart`.
- R11: With `cfgUseTxPin`=1, the sync is taken from `syncPinTx`. Otherwise it is taken from `syncPinRx`. The pin that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run when high; configuration is captured when low |
| cfgExtSync | input | 1 | 1: sync comes from a pin; 0: sync is generated and driven |
| cfgInvert | input | 1 | Sync polarity (0 rising / active high, 1 falling / active low) |
| cfgWordSync | input | 1 | 1: sync lasts one slot; 0: sync lasts one bit clock |
| cfgUseTxPin | input | 1 | External sync source: 1 transmit pin, 0 receive pin |
| cfgSlots | input | SLOT_W (9) | Slots per frame: 0 burst, 2..32, or 384 |
| cfgSlotBits | input | BIT_W (6) | Bit clocks per slot (4..32) |
| cfgDelay | input | 2 | First-data-bit delay in bit clocks (0..2) |
| burstReq | input | 1 | Burst-mode transfer request |
| syncPinTx | input | 1 | Transmit sync pin level |
| syncPinRx | input | 1 | Receive sync pin level |
| syncOut | output | 1 | Generated sync level |
| syncOe | output | 1 | Output enable for the generated sync |
| frameStart | output | 1 | High in the first bit clock of a frame |
| slotFirstBit | output | 1 | High on the delayed first data bit of each slot |
| slotIdx | output | SLOT_W (9) | Current slot index |
| syncErr | output | 1 | One-cycle pulse on a misplaced external sync edge |

## Verification
The corner cases are the following:
- The 384-slot frame. A counter that compares against a five-bit slot limit would wrap at the wrong slot.
- Each of the three data delays. An off-by-one error in the delay would move `slotFirstBit` into the wrong bit.
- Word-wide versus single-bit sync under both polarities. A design that inverts only one of them would show a wrong level somewhere in slot 0.
- A configuration change made mid-run. A design that samples live inputs would change its period at once.
- In burst mode, a request made mid-frame. If it were honoured, a second frame would follow straight away.
- In external mode: an on-time edge must not raise an error, an early edge must realign the counters and raise an error, the opposite edge under inverted polarity must be ignored, and a toggle on the unselected pin must start nothing.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic clear;    // load counters with slot 0, bit 0
    logic advance;  // step counters by one bit clock
    logic active;   // a frame is in progress
    logic drive;    // internal sync: the pin is driven
  } fsgStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HUNT = 2'd2,
    ST_RUN  = 2'd3
  } fsgState_t;
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int SLOT_W = 9,
  parameter int BIT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              burstReq,
  input  logic              cfgExtSync,
  input  logic              cfgInvert,
  input  logic              cfgWordSync,
  input  logic              cfgUseTxPin,
  input  logic [SLOT_W-1:0] cfgSlots,
  input  logic [BIT_W-1:0]  cfgSlotBits,
  input  logic [1:0]        cfgDelay,
  input  logic              extEdge,
  input  logic              atFrameEnd,
  output fsgStrobe_t        stb,
  output logic              cfgExtQ,
  output logic              cfgInvQ,
  output logic              cfgWideQ,
  output logic              cfgUseTxQ,
  output logic [1:0]        cfgDelayQ,
  output logic [SLOT_W-1:0] lastSlotQ,
  output logic [BIT_W-1:0]  lastBitQ,
  output logic              syncErr
);
  logic      burstQ;
  fsgState_t state, nextState;
  logic      errNext;

  // configuration is latched only while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgExtQ   <= 1'b0;
      cfgInvQ   <= 1'b0;
      cfgWideQ  <= 1'b0;
      cfgUseTxQ <= 1'b0;
      cfgDelayQ <= '0;
      lastSlotQ <= SLOT_W'(1);
      lastBitQ  <= BIT_W'(7);
      burstQ    <= 1'b0;
    end else if (!enable) begin
      cfgExtQ   <= cfgExtSync;
      cfgInvQ   <= cfgInvert;
      cfgWideQ  <= cfgWordSync;
      cfgUseTxQ <= cfgUseTxPin;
      cfgDelayQ <= cfgDelay;
      lastSlotQ <= (cfgSlots == '0) ? '0 : cfgSlots - 1'b1;
      lastBitQ  <= cfgSlotBits - 1'b1;
      burstQ    <= (cfgSlots == '0);
    end
  end

  always_comb begin
    nextState   = state;
    errNext     = 1'b0;
    stb.clear   = 1'b0;
    stb.advance = 1'b0;
    stb.active  = (state == ST_RUN);
    stb.drive   = (state != ST_IDLE) && !cfgExtQ;
    unique case (state)
      ST_IDLE: begin
        stb.clear = 1'b1;
        if (enable)
          nextState = cfgExtQ ? ST_HUNT : (burstQ ? ST_WAIT : ST_RUN);
      end
      ST_WAIT: begin
        if (!enable) nextState = ST_IDLE;
        else if (burstReq) begin
          stb.clear = 1'b1;
          nextState = ST_RUN;
        end
      end
      ST_HUNT: begin
        if (!enable) nextState = ST_IDLE;
        else if (extEdge) begin
          stb.clear = 1'b1;
          nextState = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!enable) begin
          stb.clear = 1'b1;
          nextState = ST_IDLE;
        end else if (cfgExtQ && extEdge) begin
          stb.clear = 1'b1;
          errNext   = !atFrameEnd;
        end else begin
          stb.advance = 1'b1;
          if (burstQ && atFrameEnd) nextState = ST_WAIT;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      syncErr <= 1'b0;
    end else begin
      state   <= nextState;
      syncErr <= errNext;
    end
  end
endmodule

// File: rtl/fsg_dp.sv
module fsg_dp
  import fsg_pkg::*;
#(
  parameter int SLOT_W = 9,
  parameter int BIT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fsgStrobe_t        stb,
  input  logic [SLOT_W-1:0] lastSlot,
  input  logic [BIT_W-1:0]  lastBit,
  input  logic [1:0]        delay,
  input  logic              invert,
  input  logic              wordWide,
  input  logic              useTxPin,
  input  logic              pinTx,
  input  logic              pinRx,
  output logic              extEdge,
  output logic              atFrameEnd,
  output logic              frameStart,
  output logic              slotFirstBit,
  output logic              syncOut,
  output logic              syncOe,
  output logic [SLOT_W-1:0] slotIdx
);
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              pinLvl, pinQ, pinPrevQ;
  logic              atSlotEnd, atFrameHead, syncActive;

  // pin capture: normalise so that 1 means active, then find the active edge
  assign pinLvl = (useTxPin ? pinTx : pinRx) ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinQ     <= 1'b0;
      pinPrevQ <= 1'b0;
    end else begin
      pinQ     <= pinLvl;
      pinPrevQ <= pinQ;
    end
  end

  assign extEdge = pinQ & ~pinPrevQ;

  // bit and slot counters
  assign atSlotEnd  = (bitCnt == lastBit);
  assign atFrameEnd = atSlotEnd && (slotCnt == lastSlot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (stb.clear) begin
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (stb.advance) begin
      if (atSlotEnd) begin
        bitCnt  <= '0;
        slotCnt <= (slotCnt == lastSlot) ? '0 : slotCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // output formation
  assign atFrameHead  = (bitCnt == '0) && (slotCnt == '0);
  assign frameStart   = stb.active && atFrameHead;
  assign slotFirstBit = stb.active && (bitCnt == BIT_W'(delay));
  assign syncActive   = wordWide ? (slotCnt == '0) : atFrameHead;
  assign syncOut      = (stb.drive && stb.active && syncActive) ^ invert;
  assign syncOe       = stb.drive;
  assign slotIdx      = slotCnt;
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int SLOT_W = 9,
  parameter int BIT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfgExtSync,
  input  logic              cfgInvert,
  input  logic              cfgWordSync,
  input  logic              cfgUseTxPin,
  input  logic [SLOT_W-1:0] cfgSlots,
  input  logic [BIT_W-1:0]  cfgSlotBits,
  input  logic [1:0]        cfgDelay,
  input  logic              burstReq,
  input  logic              syncPinTx,
  input  logic              syncPinRx,
  output logic              syncOut,
  output logic              syncOe,
  output logic              frameStart,
  output logic              slotFirstBit,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              syncErr
);
  fsgStrobe_t        stb;
  logic              cfgExtQ, cfgInvQ, cfgWideQ, cfgUseTxQ;
  logic [1:0]        cfgDelayQ;
  logic [SLOT_W-1:0] lastSlotQ;
  logic [BIT_W-1:0]  lastBitQ;
  logic              extEdge, atFrameEnd;

  fsg_ctrl #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .burstReq   (burstReq),
    .cfgExtSync (cfgExtSync),
    .cfgInvert  (cfgInvert),
    .cfgWordSync(cfgWordSync),
    .cfgUseTxPin(cfgUseTxPin),
    .cfgSlots   (cfgSlots),
    .cfgSlotBits(cfgSlotBits),
    .cfgDelay   (cfgDelay),
    .extEdge    (extEdge),
    .atFrameEnd (atFrameEnd),
    .stb        (stb),
    .cfgExtQ    (cfgExtQ),
    .cfgInvQ    (cfgInvQ),
    .cfgWideQ   (cfgWideQ),
    .cfgUseTxQ  (cfgUseTxQ),
    .cfgDelayQ  (cfgDelayQ),
    .lastSlotQ  (lastSlotQ),
    .lastBitQ   (lastBitQ),
    .syncErr    (syncErr)
  );

  fsg_dp #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .lastSlot    (lastSlotQ),
    .lastBit     (lastBitQ),
    .delay       (cfgDelayQ),
    .invert      (cfgInvQ),
    .wordWide    (cfgWideQ),
    .useTxPin    (cfgUseTxQ),
    .pinTx       (syncPinTx),
    .pinRx       (syncPinRx),
    .extEdge     (extEdge),
    .atFrameEnd  (atFrameEnd),
    .frameStart  (frameStart),
    .slotFirstBit(slotFirstBit),
    .syncOut     (syncOut),
    .syncOe      (syncOe),
    .slotIdx     (slotIdx)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int SLOT_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              frameStart,
  input logic              slotFirstBit,
  input logic              syncOut,
  input logic              syncOe,
  input logic              syncErr,
  input logic [SLOT_W-1:0] slotIdx,
  input logic              cfgExtQ,
  input logic              cfgInvQ,
  input logic              cfgWideQ,
  input logic [1:0]        cfgDelayQ
);
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!syncOe && !frameStart && !slotFirstBit && slotIdx == '0));

  assert_start_is_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> (slotIdx == '0));

  assert_start_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> !frameStart);

  assert_bit_sync_only_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (syncOe && !cfgWideQ && (syncOut != cfgInvQ)) |-> frameStart);

  assert_zero_delay_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && cfgDelayQ == 2'd0) |-> slotFirstBit);

  assert_ext_not_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfgExtQ |-> !syncOe);

  assert_err_realigns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    syncErr |-> (frameStart && cfgExtQ));

  assert_err_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    syncErr |=> !syncErr);
endmodule

bind frame_sync_gen fsg_checker #(.SLOT_W(SLOT_W)) u_fsg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .frameStart  (frameStart),
  .slotFirstBit(slotFirstBit),
  .syncOut     (syncOut),
  .syncOe      (syncOe),
  .syncErr     (syncErr),
  .slotIdx     (slotIdx),
  .cfgExtQ     (cfgExtQ),
  .cfgInvQ     (cfgInvQ),
  .cfgWideQ    (cfgWideQ),
  .cfgDelayQ   (cfgDelayQ)
);

// File: tb/frame_sync_gen_bench.sv
module frame_sync_gen_bench;
  localparam int SLOT_W = 9;
  localparam int BIT_W  = 6;

  typedef struct packed {
    logic [8:0] slots;
    logic [5:0] bits;
    logic [1:0] dly;
    logic       wide;
    logic       inv;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{slots: 9'd2,   bits: 6'd16, dly: 2'd1, wide: 1'b1, inv: 1'b0},
    '{slots: 9'd3,   bits: 6'd8,  dly: 2'd0, wide: 1'b0, inv: 1'b0},
    '{slots: 9'd8,   bits: 6'd8,  dly: 2'd2, wide: 1'b0, inv: 1'b1},
    '{slots: 9'd32,  bits: 6'd8,  dly: 2'd1, wide: 1'b1, inv: 1'b1},
    '{slots: 9'd5,   bits: 6'd12, dly: 2'd0, wide: 1'b1, inv: 1'b0},
    '{slots: 9'd384, bits: 6'd8,  dly: 2'd2, wide: 1'b0, inv: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic enable, cfgExtSync, cfgInvert, cfgWordSync, cfgUseTxPin;
  logic [SLOT_W-1:0] cfgSlots;
  logic [BIT_W-1:0]  cfgSlotBits;
  logic [1:0]        cfgDelay;
  logic burstReq, syncPinTx, syncPinRx;
  logic syncOut, syncOe, frameStart, slotFirstBit, syncErr;
  logic [SLOT_W-1:0] slotIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frame_sync_gen #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_frame_sync_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfgExtSync(cfgExtSync), .cfgInvert(cfgInvert), .cfgWordSync(cfgWordSync),
    .cfgUseTxPin(cfgUseTxPin), .cfgSlots(cfgSlots), .cfgSlotBits(cfgSlotBits),
    .cfgDelay(cfgDelay), .burstReq(burstReq), .syncPinTx(syncPinTx),
    .syncPinRx(syncPinRx), .syncOut(syncOut), .syncOe(syncOe),
    .frameStart(frameStart), .slotFirstBit(slotFirstBit), .slotIdx(slotIdx),
    .syncErr(syncErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setup(input logic ext, input logic inv, input logic wide, input logic useTx,
                       input int slots, input int bits, input int dly);
    enable      = 1'b0;
    cfgExtSync  = ext;
    cfgInvert   = inv;
    cfgWordSync = wide;
    cfgUseTxPin = useTx;
    cfgSlots    = SLOT_W'(slots);
    cfgSlotBits = BIT_W'(bits);
    cfgDelay    = 2'(dly);
    repeat (3) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; burstReq = 1'b0;
    syncPinTx = 1'b0; syncPinRx = 1'b0;
    cfgExtSync = 1'b0; cfgInvert = 1'b0; cfgWordSync = 1'b0; cfgUseTxPin = 1'b0;
    cfgSlots = 9'd2; cfgSlotBits = 6'd8; cfgDelay = 2'd0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();

    // R1: reset and disabled state
    chk(!syncOe && !frameStart && !slotFirstBit && !syncErr, "R1 idle strobes",
        {syncOe, frameStart, slotFirstBit, syncErr}, 0);
    chk(slotIdx == 0, "R1 idle slot index", slotIdx, 0);
    chk(syncOut == 1'b0, "R1 idle sync level", syncOut, 0);

    // table walk: internal periodic mode (R3 R4 R5 R6 R7)
    for (int v = 0; v < NVEC; v++) begin
      int len, mism, bad;
      setup(1'b0, VECS[v].inv, VECS[v].wide, 1'b0, VECS[v].slots, VECS[v].bits, VECS[v].dly);
      chk(syncOut == VECS[v].inv && !syncOe, "R5 inactive level while disabled",
          syncOut, VECS[v].inv);
      len = int'(VECS[v].slots) * int'(VECS[v].bits);
      mism = 0;
      bad = 0;
      enable = 1'b1;
      tick();
      for (int k = 0; k < 2 * len; k++) begin
        int bitPos, slot;
        logic expStart, expFirst, expOut;
        bitPos   = k % int'(VECS[v].bits);
        slot     = (k / int'(VECS[v].bits)) % int'(VECS[v].slots);
        expStart = (bitPos == 0) && (slot == 0);
        expFirst = (bitPos == int'(VECS[v].dly));
        expOut   = (VECS[v].wide ? (slot == 0) : expStart) ^ VECS[v].inv;
        if (frameStart !== expStart || slotFirstBit !== expFirst || syncOut !== expOut ||
            slotIdx !== SLOT_W'(slot) || syncOe !== 1'b1) begin
          if (mism == 0) bad = k;
          mism++;
        end
        tick();
      end
      if (v == 5) chk(mism == 0, "R4 384-slot frame mismatches", mism, 0);
      else        chk(mism == 0, "R3 R5 R6 R7 periodic frame mismatches", mism, 0);
      if (mism != 0) $display("  vector %0d first bad cycle %0d", v, bad);
      enable = 1'b0;
      tick();
    end

    // R2: configuration frozen while enabled
    setup(1'b0, 1'b0, 1'b0, 1'b0, 4, 8, 0);
    enable = 1'b1;
    tick();                       // k=0
    cfgSlots = 9'd2; cfgSlotBits = 6'd4;
    repeat (16) tick();           // k=16
    chk(slotIdx == 2 && !frameStart, "R2 live change ignored (slot at k=16)", slotIdx, 2);
    repeat (16) tick();           // k=32
    chk(frameStart == 1'b1, "R2 old period kept", frameStart, 1);
    enable = 1'b0;
    repeat (3) tick();
    enable = 1'b1;
    tick();                       // k=0 with new config
    repeat (8) tick();
    chk(frameStart == 1'b1, "R2 new period after re-enable", frameStart, 1);
    enable = 1'b0;
    tick();

    // R8: burst mode
    setup(1'b0, 1'b0, 1'b1, 1'b0, 0, 8, 1);
    enable = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (6) begin
        tick();
        if (frameStart || syncOut) seen++;
      end
      chk(seen == 0 && syncOe, "R8 no frame without request", seen, 0);
      burstReq = 1'b1;
      tick();
      burstReq = 1'b0;            // k=0
      chk(frameStart && syncOut && slotIdx == 0, "R8 request starts frame",
          {frameStart, syncOut}, 3);
      tick();                     // k=1
      chk(slotFirstBit == 1'b1, "R7 delayed first bit in burst", slotFirstBit, 1);
      repeat (2) tick();          // k=3
      burstReq = 1'b1;
      tick();
      burstReq = 1'b0;            // k=4
      repeat (4) tick();          // k=8
      seen = 0;
      repeat (10) begin
        if (frameStart || syncOut || slotFirstBit) seen++;
        tick();
      end
      chk(seen == 0, "R8 mid-frame request ignored", seen, 0);
      burstReq = 1'b1;
      tick();
      burstReq = 1'b0;
      chk(frameStart == 1'b1, "R8 second request starts frame", frameStart, 1);
    end
    enable = 1'b0;
    tick();

    // R9 R10: external sync from receive pin, active high
    syncPinRx = 1'b0; syncPinTx = 1'b0;
    setup(1'b1, 1'b0, 1'b0, 1'b0, 4, 8, 0);
    enable = 1'b1;
    repeat (5) tick();
    chk(!frameStart && !syncOe, "R9 no frame before edge, pin not driven",
        {frameStart, syncOe}, 0);
    syncPinRx = 1'b1;
    tick();
    chk(frameStart == 1'b0, "R9 no frame one cycle after edge", frameStart, 0);
    tick();                       // k=0
    chk(frameStart && slotIdx == 0 && !syncErr, "R9 frame aligned to edge",
        {frameStart, syncErr}, 2);
    repeat (8) tick();
    syncPinRx = 1'b0;             // k=8
    repeat (22) tick();           // k=30
    syncPinRx = 1'b1;
    tick();                       // k=31
    chk(slotIdx == 3, "R9 counting in external mode", slotIdx, 3);
    tick();                       // k=0 of next frame
    chk(frameStart && !syncErr, "R10 on-time edge raises no error",
        {frameStart, syncErr}, 2);
    repeat (4) tick();
    syncPinRx = 1'b0;             // k=4
    repeat (6) tick();
    syncPinRx = 1'b1;             // k=10
    tick();
    tick();
    chk(frameStart && syncErr && slotIdx == 0, "R10 early edge flagged and realigned",
        {frameStart, syncErr}, 3);
    tick();
    chk(syncErr == 1'b0, "R10 error is one cycle", syncErr, 0);
    enable = 1'b0;
    tick();

    // R5: external falling-edge sync
    syncPinRx = 1'b0;
    setup(1'b1, 1'b1, 1'b0, 1'b0, 4, 8, 0);
    enable = 1'b1;
    repeat (2) tick();
    syncPinRx = 1'b1;             // rising edge: inactive direction
    repeat (3) tick();
    chk(frameStart == 1'b0 && slotIdx == 0, "R5 rising edge ignored when inverted",
        frameStart, 0);
    syncPinRx = 1'b0;
    tick();
    tick();
    chk(frameStart == 1'b1, "R5 falling edge starts frame when inverted", frameStart, 1);
    enable = 1'b0;
    tick();

    // R11: receive sync taken from the transmit pin
    syncPinRx = 1'b0; syncPinTx = 1'b0;
    setup(1'b1, 1'b0, 1'b0, 1'b1, 4, 8, 0);
    enable = 1'b1;
    repeat (2) tick();
    syncPinRx = 1'b1;
    repeat (3) tick();
    chk(frameStart == 1'b0 && slotIdx == 0, "R11 unselected pin has no effect",
        frameStart, 0);
    syncPinTx = 1'b1;
    tick();
    tick();
    chk(frameStart == 1'b1, "R11 selected transmit pin starts frame", frameStart, 1);
    enable = 1'b0;
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule